// File: doc/BRIEF.md
# Three-Wire Serial Control Register Loader

This block takes program words from a three-wire serial bus (an active-low frame enable, a data line and a bit clock) and commits them into a small bank of control registers. The block runs on a fast system clock and oversamples all three bus lines through a synchronizer. While the frame enable is low, each rising edge of the bus clock shifts one data bit into a shift register. When the frame enable returns high, a complete word is split into a register address and a payload, and the payload is written into the addressed register.

The register bank is presented as one flat parallel output that divider and mode logic can use directly. There is no acknowledge, no parity and no readback. A frame whose bit count is wrong is silently dropped. Stored values change only through a committed word or a reset.

Top module: `ctl_word_loader`

## Requirements
- R1: A word is 16 bits shifted most significant bit first. Word bits [15:14] select the register and bits [13:0] are the payload. Register n appears on `regs_o[14*n +: 14]`.
- R2: A data bit is taken only on a rising edge of `bus_clk` while `bus_en` is low. Falling edges of `bus_clk` shift nothing.
- R3: While `bus_en` stays low, `regs_o` does not change, even after all 16 bits have been shifted in.
- R4: Toggling `bus_clk` and `bus_dat` while `bus_en` is high changes neither the shift state nor any register.
- R5: If `bus_en` rises after fewer or more than 16 bus clock rising edges, the frame is discarded and all registers keep their values.
- R6: There is no error check. Any payload value is stored unchanged, including all zeros and all ones.
- R7: An active-low `rst_n` clears all four registers at once, without waiting for a clock edge.
- R8: Every falling edge of `bus_en` restarts the bit count. A frame cut short by a rising edge of `bus_en` has no effect on the next frame.
- R9: A committed word changes only the addressed register. A later word to the same address replaces the earlier value.
- R10: The new value is visible on `regs_o` no later than 6 system clock cycles after the rising edge of `bus_en`. This assumes each high and low phase of `bus_clk` lasts at least 2 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Frame enable; low during a transfer, rising edge commits |
| bus_dat | input | 1 | Serial data, most significant bit first |
| bus_clk | input | 1 | Serial bit clock; data taken on its rising edge |
| regs_o | output | 56 | Four 14-bit registers, register n at bits [14n+13:14n] |

## Verification
The bench sends frames of 15 and 17 bits. A loader that commits on any count, or that lets its bit counter wrap, would overwrite a register with shifted garbage. It toggles the clock and data lines with the enable held high, which would catch a design that shifts without regard to the enable. It also aborts a frame partway and then sends a clean one, which would catch a counter that is not cleared on the next enable falling edge. It checks the registers before the enable rises and again 6 system clock cycles after it rises. This catches both an early commit and a commit that falls outside the latency bound.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  // bus line indices inside the synchronizer
  localparam int LINE_EN  = 0;
  localparam int LINE_DAT = 1;
  localparam int LINE_CLK = 2;
  localparam int NLINES   = 3;

  // synchronized bus view after edge detection
  typedef struct packed {
    logic en_lvl;    // enable level (high = idle)
    logic en_rise;   // enable low-to-high: commit point
    logic en_fall;   // enable high-to-low: frame start
    logic clk_rise;  // bus clock rising edge
    logic dat;       // data level aligned with clk_rise
  } bus_evt_t;
endpackage

// File: rtl/cwl_sync.sv
module cwl_sync
  import cwl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] raw_i,
  output bus_evt_t          evt_o
);
  logic [NLINES-1:0] cur, prv;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    // enable idles high so reset must not fake a falling edge
    localparam logic RST_V = (g == LINE_EN) ? 1'b1 : 1'b0;
    logic [STAGES:0] chain_q, chain_d;

    always_comb chain_d = {chain_q[STAGES-1:0], raw_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {(STAGES+1){RST_V}};
      else        chain_q <= chain_d;
    end

    assign cur[g] = chain_q[STAGES-1];
    assign prv[g] = chain_q[STAGES];
  end

  always_comb begin
    evt_o.en_lvl   = cur[LINE_EN];
    evt_o.en_rise  = cur[LINE_EN] & ~prv[LINE_EN];
    evt_o.en_fall  = ~cur[LINE_EN] & prv[LINE_EN];
    evt_o.clk_rise = cur[LINE_CLK] & ~prv[LINE_CLK];
    evt_o.dat      = cur[LINE_DAT];
  end
endmodule

// File: rtl/cwl_shifter.sv
module cwl_shifter
  import cwl_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int CNT_MAX = WORD_W + 1;           // saturation: "too many"
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              shift_en;

  assign shift_en = ~evt_i.en_lvl & evt_i.clk_rise;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (evt_i.en_fall) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d = {sr_q[WORD_W-2:0], evt_i.dat};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign word_o   = sr_q;
  assign commit_o = evt_i.en_rise & (cnt_q == CNT_W'(WORD_W));

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.en_lvl |=> ($stable(sr_q) && $stable(cnt_q))); // R4
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.en_fall |=> (cnt_q == '0)); // R8
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CNT_W'(CNT_MAX))); // R5
endmodule

// File: rtl/cwl_regfile.sv
module cwl_regfile #(
  parameter int ADDR_W = 2,
  parameter int PAY_W  = 14,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [PAY_W-1:0]      data_i,
  output logic [NREG*PAY_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic             hit;
    logic [PAY_W-1:0] q, d;

    assign hit = wr_i & (addr_i == ADDR_W'(g));

    always_comb d = hit ? data_i : q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign regs_o[g*PAY_W +: PAY_W] = q;
  end
endmodule

// File: rtl/ctl_word_loader.sv
module ctl_word_loader
  import cwl_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int SYNC_ST = 2,
  localparam int PAY_W  = WORD_W - ADDR_W,
  localparam int NREG   = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_dat,
  input  logic                  bus_clk,
  output logic [NREG*PAY_W-1:0] regs_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [NLINES-1:0] raw;
  bus_evt_t          evt;
  logic [WORD_W-1:0] word;
  logic              commit;

  always_comb begin
    raw           = '0;
    raw[LINE_EN]  = bus_en;
    raw[LINE_DAT] = bus_dat;
    raw[LINE_CLK] = bus_clk;
  end

  cwl_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(srst_n), .raw_i(raw), .evt_o(evt)
  );

  cwl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(srst_n), .evt_i(evt), .word_o(word), .commit_o(commit)
  );

  cwl_regfile #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_i(commit),
    .addr_i(word[WORD_W-1 -: ADDR_W]), .data_i(word[PAY_W-1:0]),
    .regs_o(regs_o)
  );

  AST_HOLD_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!srst_n)
    !evt.en_rise |=> $stable(regs_o)); // R3
  AST_HOLD_WHILE_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (evt.en_lvl && !evt.en_rise) |=> $stable(regs_o)); // R4
  AST_BAD_COUNT_DROPPED: assert property (@(posedge clk) disable iff (!srst_n)
    (evt.en_rise && !commit) |=> $stable(regs_o)); // R5
endmodule

// File: tb/ctl_word_loader_test.sv
module ctl_word_loader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_dat, bus_clk;
  logic [55:0] regs_o;

  int total = 0;
  int bad   = 0;
  logic [13:0] mdl [4];

  always #2.5 clk = ~clk;   // 200 MHz

  ctl_word_loader uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en),
    .bus_dat(bus_dat), .bus_clk(bus_clk), .regs_o(regs_o)
  );

  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0123, 16'h4ABC, 16'h8F0F, 16'hC001,
    16'h3FFF, 16'h4000, 16'hBFFF, 16'hD555
  };

  task automatic check_all(input string tag);
    for (int r = 0; r < 4; r++) begin
      total++;
      if (regs_o[14*r +: 14] !== mdl[r]) begin
        bad++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, r,
                 regs_o[14*r +: 14], mdl[r]);
      end
    end
  endtask

  // frame start plus n bits, MSB of the low n bits first; enable left low
  task automatic shift_bits(input logic [31:0] w, input int n);
    bus_en = 1'b0;
    #40;
    for (int i = n - 1; i >= 0; i--) begin
      bus_dat = w[i];
      #20 bus_clk = 1'b1;
      #40 bus_clk = 1'b0;
      #20;
    end
  endtask

  // raise enable, then wait 6 system cycles before any check (R10)
  task automatic end_frame();
    bus_en = 1'b1;
    #30;
  endtask

  task automatic send_word(input logic [15:0] w);
    shift_bits({16'h0, w}, 16);
    end_frame();
    mdl[w[15:14]] = w[13:0];
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) mdl[r] = '0;
    bus_en = 1'b1; bus_dat = 1'b0; bus_clk = 1'b0;
    rst_n = 1'b0;
    #23 rst_n = 1'b1;
    #50;
    check_all("R7 reset state");

    // vector table: R1 decode, R6 all-ones / all-zeros payloads, R9 overwrite
    for (int v = 0; v < NVEC; v++) begin
      send_word(VEC[v]);
      check_all($sformatf("R1 R6 R9 R10 vector %0d", v));
      #60;
    end

    // R3: full word shifted, enable still low -> no change yet
    shift_bits({16'h0, 16'h8123}, 16);
    #60;
    check_all("R3 before enable rise");
    end_frame();
    mdl[2] = 14'h0123;
    check_all("R10 commit latency");
    #60;

    // R5: short frame discarded
    shift_bits({16'h0, 16'h0AAA}, 15);
    end_frame();
    #60;
    check_all("R5 15-bit frame");

    // R5: long frame discarded
    shift_bits({15'h0, 17'h1_4321}, 17);
    end_frame();
    #60;
    check_all("R5 17-bit frame");

    // R4 / R2: activity while enable high is ignored
    for (int i = 0; i < 20; i++) begin
      bus_dat = i[0];
      #20 bus_clk = 1'b1;
      #40 bus_clk = 1'b0;
      #20;
    end
    check_all("R4 idle activity");

    // R8: aborted partial frame, then a clean word
    shift_bits({16'h0, 16'h00F5}, 7);
    end_frame();
    #60;
    check_all("R8 aborted frame no effect");
    send_word(16'hC2A5);
    check_all("R8 clean word after abort");
    #60;

    // R7: asynchronous clear mid-life
    #3;
    rst_n = 1'b0;
    #1;
    for (int r = 0; r < 4; r++) mdl[r] = '0;
    check_all("R7 async clear");
    #20 rst_n = 1'b1;
    #50;
    send_word(16'h7FFE);
    check_all("R1 word after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule